// File: doc/BRIEF.md
# Port Interrupt Status and Bus Strap Registers

This block holds two 32-bit registers for a controller with several storage ports. The control word carries one interrupt enable per port. It also carries read-only fields: a link-speed capability flag, the live level of the 66 MHz enable input, and four bus-mode strap levels. The straps are latched when the host bus leaves reset, and only if the bus is idle at that moment. The status word reports, for each port, whether an interrupt is pending. It also reports a pending flag from the serial management (I2C) controller. The status bits are cleared by writing ones.

Each port supplies two inputs. The first is a one-cycle pulse when a command completes. The block turns this pulse into a sticky flag. The second is a level input that stands for all of the port's other interrupt causes. A port's status bit is the OR of the two. Writing a one to the bit clears only the sticky completion flag. Any other cause that is still active keeps the bit set.

The block has a plain register interface. It takes an address, write data and a write strobe, and returns read data one cycle after a read strobe. It drives a single interrupt line. There is no streaming data path, so no valid/ready handshake is used.

Top module: `irq_strap_regs`

## Requirements
- R1: After reset, the following all hold: the status word reads 0, the port enables are 0, the strap field is 0 and `irq_out` is low.
- R2: A one-cycle `cmpl_pulse[i]` sets a sticky completion flag for port i. Status bit i (offset 0x44) reads as that flag OR `other_lvl[i]`.
- R3: A write to 0x44 with data bit i set clears only port i's completion flag. An active `other_lvl[i]` keeps status bit i at one. Data bits written as zero change nothing.
- R4: If `cmpl_pulse[i]` arrives in the same cycle as a clearing write to bit i, the completion flag stays set.
- R5: An `i2c_event` pulse sets status bit 29. Writing a one to bit 29 clears it.
- R6: Status bits 31:30 and 28:4 always read as zero.
- R7: The control word is at offset 0x40. Bits 3:0 are the read/write enables for ports 3..0. A write to 0x40 changes no other control bit.
- R8: On a low-to-high transition of `bus_rst_n`, sampled on `clk`, the block captures `strap_in[3:0]` into control bits 20:17 (`strap_in[3]` goes to bit 20, `strap_in[0]` to bit 17). The capture happens only if `bus_frame_n` and `bus_irdy_n` are both high. Otherwise the field keeps its value. A captured bit 20 of one means a 64-bit bus; zero means a 32-bit bus.
- R9: Control bit 16 reads the current level of `m66_en`. Control bit 24 reads the `LINK_3G` parameter: 1 means 3 Gb/s support and 0 means 1.5 Gb/s only.
- R10: `irq_out` is high exactly when some status bit i and enable i are both one, or when status bit 29 is set.
- R11: `reg_rdata` takes the addressed word one cycle after `reg_rd` and holds its value while `reg_rd` is low. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rst_n | input | 1 | Host bus reset level; its rising edge triggers strap capture |
| bus_frame_n | input | 1 | Bus frame signal, high when idle |
| bus_irdy_n | input | 1 | Bus initiator-ready signal, high when idle |
| strap_in | input | 4 | Strap levels: [3] wide bus, [2..0] speed-mode decode |
| m66_en | input | 1 | 66 MHz enable level |
| cmpl_pulse | input | NPORT | Per-port command-completion pulse |
| other_lvl | input | NPORT | Per-port level for all other interrupt causes |
| i2c_event | input | 1 | Pulse from the I2C controller |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Read data, registered |
| irq_out | output | 1 | Combined interrupt |

## Verification
The bench first sets the status bits through completion pulses alone, then through level causes alone, then through both at once. This separates the sticky flag from the live OR term. Clearing writes are issued with a level still active, with zero data bits, and in the same cycle as a fresh pulse. Each pattern shows whether the clear reaches only the completion flag and whether a new pulse wins over the clear. The strap field is driven through one idle and one busy bus-reset release, so a capture that ignores the idle qualifier gives a visible difference. The interrupt line is checked with the cause masked, unmasked, and raised only by the I2C flag.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;
  localparam int WORD_W      = 32;
  localparam int STRAP_W     = 4;
  localparam int BIT_M66     = 16;
  localparam int BIT_STRAP   = 17;
  localparam int BIT_LINK    = 24;
  localparam int BIT_I2C     = 29;
  localparam logic [7:0] OFS_CTRL = 8'h40;
  localparam logic [7:0] OFS_STAT = 8'h44;
  typedef logic [STRAP_W-1:0] strap_t;
endpackage

// File: rtl/port_flags.sv
module port_flags #(
  parameter int NPORT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPORT-1:0] pulse,
  input  logic [NPORT-1:0] clr,
  output logic [NPORT-1:0] flag
);
  for (genvar i = 0; i < NPORT; i++) begin : g_port
    always_ff @(posedge clk) begin
      if (!rst_n)        flag[i] <= 1'b0;
      else if (pulse[i]) flag[i] <= 1'b1;
      else if (clr[i])   flag[i] <= 1'b0;
    end

    AST_PULSE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      pulse[i] |=> flag[i]); // R4
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !pulse[i]) |=> !flag[i]); // R3
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr[i] && !pulse[i]) |=> $stable(flag[i])); // R2
  end
endmodule

// File: rtl/strap_capture.sv
module strap_capture
  import irq_regs_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   bus_rst_n,
  input  logic   bus_frame_n,
  input  logic   bus_irdy_n,
  input  strap_t strap_in,
  output strap_t straps
);
  logic bus_rst_q;
  logic take;

  assign take = bus_rst_n && !bus_rst_q && bus_frame_n && bus_irdy_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rst_q <= 1'b1;
      straps    <= '0;
    end else begin
      bus_rst_q <= bus_rst_n;
      if (take) straps <= strap_in;
    end
  end

  AST_STRAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rst_n && !bus_rst_q && bus_frame_n && bus_irdy_n)
      |=> straps == $past(strap_in)); // R8
  AST_STRAP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rst_n && !bus_rst_q && bus_frame_n && bus_irdy_n)
      |=> $stable(straps)); // R8
endmodule

// File: rtl/irq_strap_regs.sv
module irq_strap_regs
  import irq_regs_pkg::*;
#(
  parameter int   NPORT   = 4,
  parameter int   ADDR_W  = 8,
  parameter logic LINK_3G = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rst_n,
  input  logic              bus_frame_n,
  input  logic              bus_irdy_n,
  input  logic [3:0]        strap_in,
  input  logic              m66_en,
  input  logic [NPORT-1:0]  cmpl_pulse,
  input  logic [NPORT-1:0]  other_lvl,
  input  logic              i2c_event,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              reg_wr,
  input  logic              reg_rd,
  output logic [31:0]       reg_rdata,
  output logic              irq_out
);
  localparam logic [WORD_W-1:0] STAT_LIVE = {{(WORD_W-NPORT){1'b0}}, {NPORT{1'b1}}}
                                            | (WORD_W'(1) << BIT_I2C);

  logic             hit_ctrl, hit_stat;
  logic [NPORT-1:0] port_en;
  logic [NPORT-1:0] cmpl_flag;
  logic [NPORT-1:0] clr_vec;
  logic [NPORT-1:0] pstat;
  logic             i2c_pend;
  strap_t           straps;
  logic [WORD_W-1:0] ctrl_word, stat_word;
  logic             unused_wbits;

  assign hit_ctrl = (reg_addr == ADDR_W'(OFS_CTRL));
  assign hit_stat = (reg_addr == ADDR_W'(OFS_STAT));
  assign clr_vec  = (reg_wr && hit_stat) ? reg_wdata[NPORT-1:0] : '0;
  assign unused_wbits = ^{reg_wdata[31:30], reg_wdata[28:NPORT]};

  port_flags #(.NPORT(NPORT)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .pulse (cmpl_pulse),
    .clr   (clr_vec),
    .flag  (cmpl_flag)
  );

  strap_capture u_strap (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_rst_n   (bus_rst_n),
    .bus_frame_n (bus_frame_n),
    .bus_irdy_n  (bus_irdy_n),
    .strap_in    (strap_in),
    .straps      (straps)
  );

  assign pstat = cmpl_flag | other_lvl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      port_en  <= '0;
      i2c_pend <= 1'b0;
    end else begin
      if (reg_wr && hit_ctrl) port_en <= reg_wdata[NPORT-1:0];
      if (i2c_event)                                i2c_pend <= 1'b1;
      else if (reg_wr && hit_stat && reg_wdata[BIT_I2C]) i2c_pend <= 1'b0;
    end
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[NPORT-1:0]                  = port_en;
    ctrl_word[BIT_M66]                    = m66_en;
    ctrl_word[BIT_STRAP +: STRAP_W]       = straps;
    ctrl_word[BIT_LINK]                   = LINK_3G;
    stat_word = '0;
    stat_word[NPORT-1:0]                  = pstat;
    stat_word[BIT_I2C]                    = i2c_pend;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      if (hit_ctrl)      reg_rdata <= ctrl_word;
      else if (hit_stat) reg_rdata <= stat_word;
      else               reg_rdata <= '0;
    end
  end

  assign irq_out = (|(pstat & port_en)) | i2c_pend;

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && hit_stat) |=> (reg_rdata & ~STAT_LIVE) == '0); // R6
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata)); // R11
  AST_I2C_SET: assert property (@(posedge clk) disable iff (!rst_n)
    i2c_event |=> i2c_pend); // R5
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en == '0 && !i2c_pend) |-> !irq_out); // R10
  AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && hit_ctrl) |=> port_en == $past(reg_wdata[NPORT-1:0])); // R7
endmodule

// File: tb/irq_strap_regs_test.sv
`timescale 1ns/1ps
module irq_strap_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_rst_n = 1'b0, bus_frame_n = 1'b1, bus_irdy_n = 1'b1;
  logic [3:0]  strap_in = 4'b1011;
  logic        m66_en = 1'b0;
  logic [3:0]  cmpl_pulse = '0, other_lvl = '0;
  logic        i2c_event = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_rdata;
  logic        irq_out;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_pend = 1'b0;
  logic        done = 1'b0;

  always #4 clk = ~clk;

  irq_strap_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_rst_n(bus_rst_n), .bus_frame_n(bus_frame_n),
    .bus_irdy_n(bus_irdy_n), .strap_in(strap_in), .m66_en(m66_en),
    .cmpl_pulse(cmpl_pulse), .other_lvl(other_lvl), .i2c_event(i2c_event),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  always @(posedge clk) rd_pend <= reg_rd;

  // Monitor: pops the expected word for each completed read
  initial begin
    forever begin
      @(negedge clk);
      if (rd_pend && exp_q.size() > 0) begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (reg_rdata !== e) begin
          errors++;
          $display("FAIL %s: rdata actual %h expected %h", t, reg_rdata, e);
        end
      end
    end
  end

  task automatic chk(input logic act, input logic exp, input string t);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", t, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    reg_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] pul);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1; cmpl_pulse = pul;
    @(negedge clk);
    reg_wr = 1'b0; cmpl_pulse = '0;
  endtask

  task automatic pulse(input logic [3:0] p);
    @(negedge clk);
    cmpl_pulse = p;
    @(negedge clk);
    cmpl_pulse = '0;
  endtask

  localparam logic [7:0] CTRL = 8'h40, STAT = 8'h44;
  logic [31:0] cbase;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(irq_out, 1'b0, "R1 irq after reset");
    rd(STAT, 32'h0, "R1 status reset");
    rd(CTRL, 32'h0100_0000, "R1 control reset, R9 link bit");

    // R8: idle bus release captures straps
    m66_en = 1'b1;
    @(negedge clk); bus_rst_n = 1'b1;
    @(negedge clk);
    cbase = 32'h0100_0000 | (32'h1 << 16) | (32'hB << 17);
    rd(CTRL, cbase, "R8 idle capture, R9 m66 live");
    // busy bus release: no capture
    strap_in = 4'b0100; bus_rst_n = 1'b0; bus_frame_n = 1'b0;
    @(negedge clk); bus_rst_n = 1'b1;
    @(negedge clk); bus_frame_n = 1'b1;
    rd(CTRL, cbase, "R8 busy release keeps straps");
    m66_en = 1'b0;
    rd(CTRL, cbase & ~(32'h1 << 16), "R9 m66 follows input");
    m66_en = 1'b1;

    // R7 enables only
    wr(CTRL, 32'hFFFF_FFFF, 4'h0);
    rd(CTRL, cbase | 32'hF, "R7 write all ones");
    wr(CTRL, 32'h0000_0004, 4'h0);
    rd(CTRL, cbase | 32'h4, "R7 enable pattern");

    // R2 + R10
    pulse(4'b0010);
    rd(STAT, 32'h2, "R2 completion sticky");
    chk(irq_out, 1'b0, "R10 masked port");
    other_lvl = 4'b0100;
    @(negedge clk);
    chk(irq_out, 1'b1, "R10 enabled level");
    rd(STAT, 32'h6, "R2 level OR flag");
    wr(CTRL, 32'h0, 4'h0);
    @(negedge clk);
    chk(irq_out, 1'b0, "R10 enables cleared");

    // R3 clear only completion flag
    wr(STAT, 32'h2, 4'h0);
    rd(STAT, 32'h4, "R3 clear port1");
    pulse(4'b0100);
    wr(STAT, 32'h4, 4'h0);
    rd(STAT, 32'h4, "R3 level keeps bit");
    other_lvl = 4'b0000;
    @(negedge clk);
    rd(STAT, 32'h0, "R3 bit falls with level");
    pulse(4'b0001);
    wr(STAT, 32'h0, 4'h0);
    rd(STAT, 32'h1, "R3 zero write no effect");

    // R4 pulse beats clear
    wr(STAT, 32'h9, 4'b1000);
    rd(STAT, 32'h8, "R4 pulse with clear");
    wr(STAT, 32'h8, 4'h0);
    rd(STAT, 32'h0, "R4 later clear works");

    // R5 i2c
    @(negedge clk); i2c_event = 1'b1;
    @(negedge clk); i2c_event = 1'b0;
    chk(irq_out, 1'b1, "R5 i2c drives irq, R10");
    rd(STAT, 32'h2000_0000, "R5 i2c pending");
    wr(STAT, 32'h2000_0000, 4'h0);
    rd(STAT, 32'h0, "R5 i2c cleared");
    chk(irq_out, 1'b0, "R10 irq idle");

    // R6 reserved bits
    pulse(4'hF);
    @(negedge clk); i2c_event = 1'b1;
    @(negedge clk); i2c_event = 1'b0;
    rd(STAT, 32'h2000_000F, "R6 reserved zero");
    wr(STAT, 32'hFFFF_FFFF, 4'h0);
    rd(STAT, 32'h0, "R6 clear all");

    // R11 unmapped and hold
    rd(8'h48, 32'h0, "R11 unmapped");
    rd(CTRL, cbase, "R11 control read");
    repeat (3) @(negedge clk);
    checks++;
    if (reg_rdata !== cbase) begin
      errors++;
      $display("FAIL R11 hold: actual %h expected %h", reg_rdata, cbase);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule